// File: doc/BRIEF.md
# Dual-Bank Flash Operation Arbiter

This block sits between a host bus and a two-bank flash array. It keeps a mode for each bank: read, autoselect, program, erase, erase held in suspend, or program during a suspended erase. It works out which bank every access targets from the upper address bits, in the same cycle. A command may start a long operation in one bank while the other bank goes on serving array reads. A command that would leave both banks off read mode is refused. A one-cycle acknowledge or reject pulse reports the outcome.

For reads, the block selects where the data comes from: the array, the identifier space, or the status word of a busy bank. It also produces the output-drive enable from the chip-enable, output-enable and write-enable controls. The program and erase engines report completion with per-bank done pulses. The bank boundary is set at build time. One 64 KB-sized unit holds the eight small boot sectors, at the bottom or the top of the map. The boot-side bank holds 1, 8, 16 or 32 units and the other bank holds the rest of the 64 units.

Top module: `dbank_arbiter`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, both bank modes are read (code 0), `cmd_ack` and `cmd_rej` are low, and no sector is held suspended.
- R2: `rd_bank` follows the address in the same cycle with no register. With bottom boot, bank 0 is chosen when `addr[20:15]` is below the bank-0 unit count. The count is 1, 8, 16 or 32 for `VARIANT` 0 to 3. With top boot, bank 0 is chosen when `addr[20:15]` is at or above 64 minus that count.
- R3: A command is taken only in a cycle where `cmd_stb` is high with `ce_n` low and `we_n` low. A strobe with either control high is ignored: no pulse, no mode change.
- R4: The mode codes are read 0, autoselect 1, program 2, erase 3, suspended 4 and suspended-program 5. The command codes act on the addressed bank as follows:
  - 0 returns read or autoselect to read.
  - 1 enters autoselect.
  - 2 starts a program.
  - 3 starts an erase.
  - 4 suspends an erase.
  - 5 resumes a suspended erase.

  An accepted command sets the new mode at the next edge and raises `cmd_ack` for one cycle.
- R5: Autoselect, program and erase may start from read only while the other bank is in read. At every cycle at least one bank is in read.
- R6: A refused command raises `cmd_rej` for one cycle and leaves both modes unchanged. Refused commands are codes 6 and 7, a command not allowed from the current mode, an illegal pair, and a command in the same cycle as any done pulse.
- R7: At the next edge, `prog_done` moves program to read and suspended-program to suspended, and `erase_done` moves erase to read. A done pulse for a bank in any other mode is ignored.
- R8: While `rd_src` is not 0, it names the source for the addressed bank: 1 for the array in read, 2 for the identifier in autoselect, and 3 for status in program, erase or suspended-program. It is 0 when no read is under way.
- R9: Starting an erase records the target sector. In the boot unit a sector is the 8 KB slice chosen by `addr[14:12]`; elsewhere it is the whole 64 KB unit. While suspended, reads of any other sector give 1 and reads of the recorded sector give 3. A program to the recorded sector is refused, and a program to any other sector of that bank enters suspended-program.
- R10: `dq_oe` is high exactly when `ce_n` and `oe_n` are low and `we_n` is high.
- R11: After reset, `rd_src` stays 0 until `ce_n` has changed level, or `addr` has changed, between two consecutive clock edges.
- R12: A reset during a suspended erase drops the suspension, and a later program to the formerly suspended sector is accepted from read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| addr | input | ADDR_W | Host address |
| ce_n | input | 1 | Device select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write enable, active low |
| cmd_stb | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| prog_done | input | 2 | Program finished, one bit per bank |
| erase_done | input | 2 | Erase finished, one bit per bank |
| mode_b0 | output | 3 | Mode of bank 0 (boot side) |
| mode_b1 | output | 3 | Mode of bank 1 |
| cmd_ack | output | 1 | Command accepted, one cycle |
| cmd_rej | output | 1 | Command refused, one cycle |
| rd_bank | output | 1 | Bank addressed this cycle |
| rd_src | output | 2 | Read data source select |
| dq_oe | output | 1 | Data output drive enable |

## Verification
The assertions assume that done pulses come only from the engines, so a pulse for a bank not running that operation is harmless but never needed. They also assume that a command is held for exactly one strobed cycle. The stimulus keeps each strobe to a single cycle and changes inputs only at the falling edge. It raises a done pulse only for a bank whose mode the bench model shows as busy, except in one deliberate stray pulse and one deliberate clash with a command. Reads and commands are never mixed in one cycle, because a command cycle holds write enable low.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

  typedef enum logic [2:0] {
    M_READ   = 3'd0,
    M_AUTO   = 3'd1,
    M_PROG   = 3'd2,
    M_ERASE  = 3'd3,
    M_ESUSP  = 3'd4,
    M_ESPROG = 3'd5
  } bmode_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_IDENT  = 2'd2,
    SRC_STATUS = 2'd3
  } rsrc_e;

  localparam logic [2:0] CMD_TO_READ = 3'd0;
  localparam logic [2:0] CMD_AUTO    = 3'd1;
  localparam logic [2:0] CMD_PROG    = 3'd2;
  localparam logic [2:0] CMD_ERASE   = 3'd3;
  localparam logic [2:0] CMD_SUSP    = 3'd4;
  localparam logic [2:0] CMD_RESUME  = 3'd5;

  typedef struct packed {
    logic   ok;
    bmode_e nxt;
  } cmd_res_t;

  // Legality of one command against the pair of bank modes.
  function automatic cmd_res_t cmd_eval(bmode_e own_m, bmode_e peer_m,
                                        logic [2:0] code, logic on_susp);
    cmd_res_t r;
    r.ok  = 1'b0;
    r.nxt = own_m;
    case (code)
      CMD_TO_READ: if (own_m == M_READ || own_m == M_AUTO) begin
        r.ok = 1'b1; r.nxt = M_READ;
      end
      CMD_AUTO: if (own_m == M_READ && peer_m == M_READ) begin
        r.ok = 1'b1; r.nxt = M_AUTO;
      end
      CMD_PROG: begin
        if (own_m == M_READ && peer_m == M_READ) begin
          r.ok = 1'b1; r.nxt = M_PROG;
        end else if (own_m == M_ESUSP && !on_susp) begin
          r.ok = 1'b1; r.nxt = M_ESPROG;
        end
      end
      CMD_ERASE: if (own_m == M_READ && peer_m == M_READ) begin
        r.ok = 1'b1; r.nxt = M_ERASE;
      end
      CMD_SUSP: if (own_m == M_ERASE) begin
        r.ok = 1'b1; r.nxt = M_ESUSP;
      end
      CMD_RESUME: if (own_m == M_ESUSP) begin
        r.ok = 1'b1; r.nxt = M_ERASE;
      end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  // Data source for a read aimed at a bank in mode m.
  function automatic rsrc_e read_src(bmode_e m, logic on_susp);
    case (m)
      M_READ:  return SRC_ARRAY;
      M_AUTO:  return SRC_IDENT;
      M_ESUSP: return on_susp ? SRC_STATUS : SRC_ARRAY;
      default: return SRC_STATUS;
    endcase
  endfunction

endpackage

// File: rtl/dbank_decode.sv
module dbank_decode #(
  parameter int UNIT_W  = 6,
  parameter int SUB_W   = 3,
  parameter int VARIANT = 3,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [UNIT_W+SUB_W-1:0] upper,
  output logic                    bank_sel,
  output logic [UNIT_W+SUB_W-1:0] sector
);

  localparam int UNITS = 1 << UNIT_W;

  function automatic int boot_side_units(int v);
    case (v)
      0:       return 1;
      1:       return 8;
      2:       return 16;
      default: return 32;
    endcase
  endfunction

  localparam int B0_UNITS = boot_side_units(VARIANT);

  function automatic logic on_boot_side(logic [UNIT_W-1:0] u);
    if (TOP_BOOT) return int'(u) >= UNITS - B0_UNITS;
    else          return int'(u) < B0_UNITS;
  endfunction

  function automatic logic is_boot_unit(logic [UNIT_W-1:0] u);
    if (TOP_BOOT) return int'(u) == UNITS - 1;
    else          return u == '0;
  endfunction

  logic [UNIT_W-1:0] unit_idx;
  logic [SUB_W-1:0]  sub_idx;

  assign unit_idx = upper[UNIT_W+SUB_W-1:SUB_W];
  assign sub_idx  = upper[SUB_W-1:0];
  assign bank_sel = ~on_boot_side(unit_idx);
  assign sector   = {unit_idx, is_boot_unit(unit_idx) ? sub_idx : {SUB_W{1'b0}}};

endmodule

// File: rtl/dbank_bank_fsm.sv
module dbank_bank_fsm
  import dbank_pkg::*;
#(
  parameter int SEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  bmode_e           nxt,
  input  logic [SEC_W-1:0] sector,
  input  logic             prog_done,
  input  logic             erase_done,
  output bmode_e           mode,
  output logic [SEC_W-1:0] susp_sector
);

  bmode_e           mode_q;
  logic [SEC_W-1:0] susp_q;
  logic             pdone_hit;
  logic             edone_hit;

  assign pdone_hit = prog_done && (mode_q == M_PROG || mode_q == M_ESPROG);
  assign edone_hit = erase_done && (mode_q == M_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_READ;
      susp_q <= '0;
    end else if (pdone_hit) begin
      mode_q <= (mode_q == M_ESPROG) ? M_ESUSP : M_READ;
    end else if (edone_hit) begin
      mode_q <= M_READ;
    end else if (take) begin
      mode_q <= nxt;
      if (nxt == M_ERASE && mode_q == M_READ) susp_q <= sector;
    end
  end

  assign mode        = mode_q;
  assign susp_sector = susp_q;

  AST_PROG_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PROG && prog_done) |=> (mode_q == M_READ)); // R7
  AST_ERASE_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ERASE && erase_done) |=> (mode_q == M_READ)); // R7
  AST_SUSP_SECTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ESUSP) |=> $stable(susp_q)); // R9

endmodule

// File: rtl/dbank_read_gate.sv
module dbank_read_gate
  import dbank_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  bmode_e            mode_sel,
  input  logic              hit_sel,
  output rsrc_e             rd_src,
  output logic              dq_oe
);

  logic              prev_ce_n_q;
  logic [ADDR_W-1:0] prev_addr_q;
  logic              primed_q;
  logic              wake_event;
  logic              rd_en;

  // Either a change of chip enable level or of address arms the sense path.
  assign wake_event = (ce_n != prev_ce_n_q) || (addr != prev_addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ce_n_q <= 1'b0;
      prev_addr_q <= '0;
      primed_q    <= 1'b0;
    end else begin
      prev_ce_n_q <= ce_n;
      prev_addr_q <= addr;
      if (wake_event) primed_q <= 1'b1;
    end
  end

  assign rd_en  = ~ce_n & ~oe_n & we_n;
  assign dq_oe  = rd_en;
  assign rd_src = (rd_en && primed_q) ? read_src(mode_sel, hit_sel) : SRC_NONE;

  AST_SRC_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src != SRC_NONE) |-> (!ce_n && !oe_n)); // R10

endmodule

// File: rtl/dbank_arbiter.sv
module dbank_arbiter
  import dbank_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int UNIT_W   = 6,
  parameter int SUB_W    = 3,
  parameter int VARIANT  = 3,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              cmd_stb,
  input  logic [2:0]        cmd_code,
  input  logic [1:0]        prog_done,
  input  logic [1:0]        erase_done,
  output logic [2:0]        mode_b0,
  output logic [2:0]        mode_b1,
  output logic              cmd_ack,
  output logic              cmd_rej,
  output logic              rd_bank,
  output logic [1:0]        rd_src,
  output logic              dq_oe
);

  localparam int SEC_W   = UNIT_W + SUB_W;
  localparam int SUB_LSB = ADDR_W - SEC_W;

  logic             bank_sel;
  logic [SEC_W-1:0] sector;
  bmode_e           mode_q [2];
  logic [SEC_W-1:0] susp_q [2];
  logic [1:0]       hit;
  cmd_res_t         ev;
  logic             cmd_fire;
  logic             any_done;
  logic             cmd_ok;
  rsrc_e            src;
  logic             ack_q, rej_q;

  dbank_decode #(
    .UNIT_W(UNIT_W), .SUB_W(SUB_W), .VARIANT(VARIANT), .TOP_BOOT(TOP_BOOT)
  ) u_dec (
    .upper    (addr[ADDR_W-1:SUB_LSB]),
    .bank_sel (bank_sel),
    .sector   (sector)
  );

  assign cmd_fire = cmd_stb & ~ce_n & ~we_n;
  assign any_done = (|prog_done) | (|erase_done);
  assign ev       = cmd_eval(mode_q[bank_sel], mode_q[~bank_sel], cmd_code, hit[bank_sel]);
  assign cmd_ok   = cmd_fire & ev.ok & ~any_done;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign hit[b] = (sector == susp_q[b]);
    dbank_bank_fsm #(.SEC_W(SEC_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (cmd_ok && (bank_sel == 1'(b))),
      .nxt         (ev.nxt),
      .sector      (sector),
      .prog_done   (prog_done[b]),
      .erase_done  (erase_done[b]),
      .mode        (mode_q[b]),
      .susp_sector (susp_q[b])
    );
  end

  dbank_read_gate #(.ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .addr     (addr),
    .mode_sel (mode_q[bank_sel]),
    .hit_sel  (hit[bank_sel]),
    .rd_src   (src),
    .dq_oe    (dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      ack_q <= cmd_ok;
      rej_q <= cmd_fire & ~cmd_ok;
    end
  end

  assign mode_b0 = mode_q[0];
  assign mode_b1 = mode_q[1];
  assign cmd_ack = ack_q;
  assign cmd_rej = rej_q;
  assign rd_bank = bank_sel;
  assign rd_src  = src;

  AST_ONE_BANK_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b0 == 3'd0) || (mode_b1 == 3'd0)); // R5
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> $past(cmd_stb && !ce_n && !we_n)); // R3
  AST_REJ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rej |-> $past(cmd_stb && !ce_n && !we_n)); // R6
  AST_REJ_KEEPS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rej |-> ($past(any_done) ||
                 (mode_b0 == $past(mode_b0) && mode_b1 == $past(mode_b1)))); // R6
  AST_ARRAY_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src == 2'd1) |-> (mode_q[rd_bank] == M_READ || mode_q[rd_bank] == M_ESUSP)); // R8

endmodule

// File: tb/dbank_arbiter_tb_top.sv
module dbank_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [20:0] addr;
  logic        ce_n, oe_n, we_n, cmd_stb;
  logic [2:0]  cmd_code;
  logic [1:0]  prog_done, erase_done;
  logic [2:0]  mode_b0, mode_b1;
  logic        cmd_ack, cmd_rej, rd_bank, dq_oe;
  logic [1:0]  rd_src;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [11:0] vec;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  dbank_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .prog_done(prog_done),
    .erase_done(erase_done), .mode_b0(mode_b0), .mode_b1(mode_b1),
    .cmd_ack(cmd_ack), .cmd_rej(cmd_rej), .rd_bank(rd_bank), .rd_src(rd_src),
    .dq_oe(dq_oe)
  );

  // Bank 0 covers the low half of the address space with the default build.
  function automatic logic exp_bank(logic [20:0] a);
    return (a >= 21'h100000);
  endfunction

  function automatic logic [20:0] unit_a(int u);
    return 21'(u) << 15;
  endfunction

  function automatic logic [20:0] boot_a(int s);
    return 21'(s) << 12;
  endfunction

  task automatic cyc(input logic ce, oe, we, stb, input logic [2:0] code,
                     input logic [20:0] a, input logic [1:0] pd, ed,
                     input logic [2:0] e0, e1, input logic eack, erej,
                     input logic [1:0] esrc, input string req);
    exp_t e;
    @(negedge clk);
    ce_n = ce; oe_n = oe; we_n = we; cmd_stb = stb; cmd_code = code;
    addr = a; prog_done = pd; erase_done = ed;
    @(posedge clk);
    #2;
    e.vec = {e0, e1, eack, erej, esrc, exp_bank(a), (!ce && !oe && we)};
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic rd(input logic [20:0] a, input logic [2:0] e0, e1,
                    input logic [1:0] esrc, input string req);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, a, 2'b00, 2'b00, e0, e1, 1'b0, 1'b0, esrc, req);
  endtask

  task automatic cmd(input logic [2:0] code, input logic [20:0] a,
                     input logic [2:0] e0, e1, input logic eack, erej, input string req);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, code, a, 2'b00, 2'b00, e0, e1, eack, erej, 2'd0, req);
  endtask

  task automatic idle(input logic [1:0] pd, ed, input logic [2:0] e0, e1, input string req);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 21'd0, pd, ed, e0, e1, 1'b0, 1'b0, 2'd0, req);
  endtask

  // Monitor: pops expectations and compares them with the outputs.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [11:0] act;
        e = sb_q.pop_front();
        act = {mode_b0, mode_b1, cmd_ack, cmd_rej, rd_src, rd_bank, dq_oe};
        checks++;
        if (act !== e.vec) begin
          fails++;
          $display("FAIL %s: actual m0=%0d m1=%0d ack=%0b rej=%0b src=%0d bank=%0b oe=%0b expected m0=%0d m1=%0d ack=%0b rej=%0b src=%0d bank=%0b oe=%0b",
                   e.req, act[11:9], act[8:6], act[5], act[4], act[3:2], act[1], act[0],
                   e.vec[11:9], e.vec[8:6], e.vec[5], e.vec[4], e.vec[3:2], e.vec[1], e.vec[0]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual run still going expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; cmd_stb = 1'b0;
    cmd_code = 3'd0; addr = 21'd0; prog_done = 2'b00; erase_done = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 no valid read with CE held low at unchanged address
    rd(21'd0, 3'd0, 3'd0, 2'd0, "R1 reset state");
    rd(21'd0, 3'd0, 3'd0, 2'd0, "R11 unprimed read");
    idle(2'b00, 2'b00, 3'd0, 3'd0, "R10 CE high no drive");
    rd(21'd0, 3'd0, 3'd0, 2'd1, "R11 primed after CE change");
    // R2 boundary of the boot-side bank
    rd(unit_a(31), 3'd0, 3'd0, 2'd1, "R2 last unit of bank 0");
    rd(unit_a(32), 3'd0, 3'd0, 2'd1, "R2 first unit of bank 1");
    // R4 / R5 program in bank 1 while bank 0 reads
    cmd(3'd2, unit_a(40), 3'd0, 3'd2, 1'b1, 1'b0, "R4 program start");
    rd(unit_a(5), 3'd0, 3'd2, 2'd1, "R5 read other bank during program");
    rd(unit_a(40), 3'd0, 3'd2, 2'd3, "R8 busy bank gives status");
    cmd(3'd1, unit_a(5), 3'd0, 3'd2, 1'b0, 1'b1, "R5 autoselect refused while peer busy");
    idle(2'b10, 2'b00, 3'd0, 3'd0, "R7 program done returns read");
    cmd(3'd1, unit_a(5), 3'd1, 3'd0, 1'b1, 1'b0, "R4 autoselect entry");
    rd(unit_a(5), 3'd1, 3'd0, 2'd2, "R8 identifier source");
    rd(unit_a(40), 3'd1, 3'd0, 2'd1, "R5 read peer during autoselect");
    cmd(3'd3, unit_a(40), 3'd1, 3'd0, 1'b0, 1'b1, "R5 erase refused while peer in autoselect");
    cmd(3'd0, unit_a(5), 3'd0, 3'd0, 1'b1, 1'b0, "R4 back to read");
    // R9 erase, suspend, sector checks
    cmd(3'd3, boot_a(3), 3'd3, 3'd0, 1'b1, 1'b0, "R4 erase start");
    idle(2'b01, 2'b00, 3'd3, 3'd0, "R7 stray program done ignored");
    cmd(3'd4, boot_a(3), 3'd4, 3'd0, 1'b1, 1'b0, "R4 suspend");
    rd(boot_a(4), 3'd4, 3'd0, 2'd1, "R9 read other boot sector");
    rd(boot_a(3), 3'd4, 3'd0, 2'd3, "R9 read erased sector");
    rd(unit_a(5), 3'd4, 3'd0, 2'd1, "R9 read other unit");
    cmd(3'd2, boot_a(3), 3'd4, 3'd0, 1'b0, 1'b1, "R9 program erased sector refused");
    cmd(3'd2, boot_a(4), 3'd5, 3'd0, 1'b1, 1'b0, "R9 program other sector");
    rd(boot_a(4), 3'd5, 3'd0, 2'd3, "R8 status during suspended program");
    cmd(3'd2, unit_a(40), 3'd5, 3'd0, 1'b0, 1'b1, "R5 program in peer refused");
    idle(2'b01, 2'b00, 3'd4, 3'd0, "R7 program done returns suspended");
    cmd(3'd5, boot_a(3), 3'd3, 3'd0, 1'b1, 1'b0, "R4 resume");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 3'd4, boot_a(3), 2'b00, 2'b01,
        3'd0, 3'd0, 1'b0, 1'b1, 2'd0, "R6 command clashing with done");
    cmd(3'd7, unit_a(5), 3'd0, 3'd0, 1'b0, 1'b1, "R6 unknown code");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 3'd1, unit_a(5), 2'b00, 2'b00,
        3'd0, 3'd0, 1'b0, 1'b0, 2'd0, "R3 strobe with CE high");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 3'd1, unit_a(5), 2'b00, 2'b00,
        3'd0, 3'd0, 1'b0, 1'b0, 2'd0, "R3 strobe with WE high");
    idle(2'b00, 2'b00, 3'd0, 3'd0, "R3 nothing taken");
    // R12 reset while suspended
    cmd(3'd3, boot_a(3), 3'd3, 3'd0, 1'b1, 1'b0, "R4 erase again");
    cmd(3'd4, boot_a(3), 3'd4, 3'd0, 1'b1, 1'b0, "R4 suspend again");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2'b00, 2'b00, 3'd0, 3'd0, "R12 reset clears modes");
    cmd(3'd2, boot_a(3), 3'd2, 3'd0, 1'b1, 1'b0, "R12 program after reset");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule